// File: doc/BRIEF.md
# Banked Processor Status Register Unit

This unit holds the live status word of a small processor core, together with one saved copy of that word for each of the five exception modes. The rest of the core reads four things from the live word: the condition flags, the interrupt masks, the instruction-state selection and the current mode. Four kinds of update change the word. The ALU posts condition flags. Saturating arithmetic posts a sticky overflow bit. The move-to-status path writes bytes under a mask. The exception path switches mode and saves the previous word.

Exception requests arrive as a seven-bit vector, and the unit serves one of them per cycle by fixed priority. On entry, one cycle does all of the following:
- copies the live word into the saved slot of the target mode;
- loads the target mode;
- masks interrupts;
- returns the core to 32-bit instruction state.

A restore request copies the saved word of the active mode back into the live word. The read port returns either the live word or the saved word of the active mode.

Top module: `psr_bank`

## Requirements
- R1: After reset the live word is 0x000000D3 (supervisor mode, both interrupt masks set), and every saved word is 0x00000010.
- R2: A flag update writes flag_nzcv into bits 31:28 of the live word. cond_nzcv always equals bits 31:28, and the saturation bit 27 never reaches cond_nzcv.
- R3: A saturation pulse sets bit 27. Bit 27 then stays set until a live-word write whose mask has bit 3 set takes bit 27 from msr_data, or until a restore reloads it.
- R4: A live-word write replaces byte k (bits 8k+7:8k) for each msr_bmask bit k that is set. The implemented bits are 31:27, 24 and 7:0. All other bits always read as zero.
- R5: In user mode (10000) only byte 3 of the live word is writable. Writes to bytes 2:0 are ignored.
- R6: The mode field accepts only these encodings: 10000 user, 10001 fast interrupt, 10010 interrupt, 10011 supervisor, 10111 abort, 11011 undefined, 11111 system. A control-byte write that carries any other mode still writes bits 7:5 and keeps the old mode.
- R7: Exception entry saves the old live word into the saved slot of the target mode. It loads the target mode, sets bit 7 (interrupt mask), and clears bit 5 (16-bit state) and bit 24 (bytecode state). It sets bit 6 (fast-interrupt mask) only for reset and fast interrupt. All other bits are kept.
- R8: exc_req bit i means: 0 reset (supervisor), 1 data abort (abort), 2 fast interrupt (fast interrupt), 3 interrupt (interrupt), 4 prefetch abort (abort), 5 undefined instruction (undefined), 6 software interrupt (supervisor). When several bits are set, the lowest index wins.
- R9: A restore copies the saved word of the active mode into the live word. If the saved mode field is not a legal encoding, the old mode is kept. In user and system modes a restore has no effect.
- R10: Saved slots are ordered fast interrupt, interrupt, supervisor, abort, undefined. With msr_saved=1, a write updates the masked bytes of the active mode's saved slot, and rd_saved=1 reads that slot back. In user and system modes such writes are ignored and the read returns zero.
- R11: Within one cycle, exception entry takes precedence over restore. Restore takes precedence over writes and over flag and saturation updates. A live-word write to byte 3 overrides a same-cycle flag update and saturation pulse.
- R12: isa_state is 2'b10 whenever bit 24 is set. Otherwise it is {1'b0, bit 5}: 00 is 32-bit state and 01 is 16-bit state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_we | input | 1 | ALU flag update strobe |
| flag_nzcv | input | 4 | New N, Z, C, V flags |
| sat_set | input | 1 | Saturation overflow pulse |
| msr_we | input | 1 | Status write strobe |
| msr_saved | input | 1 | Write targets the saved word of the active mode |
| msr_bmask | input | 4 | Byte-field write mask |
| msr_data | input | 32 | Status write data |
| exc_req | input | 7 | Exception entry requests, bit 0 highest priority |
| ret_req | input | 1 | Restore live word from saved word |
| rd_saved | input | 1 | Read port selects the saved word |
| rd_data | output | 32 | Live word or saved word of the active mode |
| cur_mode | output | 5 | Current mode field |
| irq_off | output | 1 | Normal interrupts masked |
| fiq_off | output | 1 | Fast interrupts masked |
| isa_state | output | 2 | Instruction state |
| cond_nzcv | output | 4 | Condition flags for condition evaluation |

## Verification
The assertions check the following on every cycle:
- the mode field always holds a legal encoding, and reserved bits read zero;
- the saturation bit stays set unless a byte-3 write or a restore is present;
- an exception always leaves interrupts masked and the core in 32-bit state, and a lone fast interrupt masks fast interrupts;
- user mode can neither change its control byte nor leave except through an exception;
- the arbiter's winner is always the lowest pending request.

Only the bench scenarios show the values carried along:
- which saved slot receives the old word;
- the full priority order across all 127 request patterns;
- byte masking under every mask value;
- the restored contents;
- same-cycle precedence against a reference model.

// File: rtl/psr_pkg.sv
package psr_pkg;
   localparam int PSR_W  = 32;
   localparam int MODE_W = 5;
   localparam int EXC_N  = 7;
   localparam int BANK_N = 5;

   localparam int BIT_N = 31;
   localparam int BIT_V = 28;
   localparam int BIT_Q = 27;
   localparam int BIT_J = 24;
   localparam int BIT_I = 7;
   localparam int BIT_F = 6;
   localparam int BIT_T = 5;

   localparam logic [31:0] LIVE_BITS  = 32'hF900_00FF;
   localparam logic [31:0] BOOT_WORD  = 32'h0000_00D3;
   localparam logic [31:0] SAVED_INIT = 32'h0000_0010;

   typedef enum logic [4:0] {
      M_USR = 5'b10000,
      M_FIQ = 5'b10001,
      M_IRQ = 5'b10010,
      M_SVC = 5'b10011,
      M_ABT = 5'b10111,
      M_UND = 5'b11011,
      M_SYS = 5'b11111
   } mode_e;

   typedef enum logic [2:0] {
      EX_RESET = 3'd0,
      EX_DABT  = 3'd1,
      EX_FIQ   = 3'd2,
      EX_IRQ   = 3'd3,
      EX_PABT  = 3'd4,
      EX_UNDEF = 3'd5,
      EX_SWI   = 3'd6
   } exc_e;

   function automatic logic mode_ok(input logic [4:0] m);
      case (m)
         M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic mode_banked(input logic [4:0] m);
      case (m)
         M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [2:0] bank_of(input logic [4:0] m);
      case (m)
         M_FIQ:   return 3'd0;
         M_IRQ:   return 3'd1;
         M_SVC:   return 3'd2;
         M_ABT:   return 3'd3;
         M_UND:   return 3'd4;
         default: return 3'd0;
      endcase
   endfunction

   function automatic logic [4:0] exc_target(input logic [2:0] e);
      case (e)
         EX_RESET: return M_SVC;
         EX_DABT:  return M_ABT;
         EX_FIQ:   return M_FIQ;
         EX_IRQ:   return M_IRQ;
         EX_PABT:  return M_ABT;
         EX_UNDEF: return M_UND;
         default:  return M_SVC;
      endcase
   endfunction
endpackage

// File: rtl/psr_exc_arb.sv
module psr_exc_arb #(
   parameter int N = 7
) (
   input  logic [N-1:0]         req,
   output logic                 hit,
   output logic [$clog2(N)-1:0] win
);
   localparam int IW = $clog2(N);

   logic [N-1:0] grant;
   logic [N:0]   blocked;

   assign blocked[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_chain
      assign grant[i]     = req[i] & ~blocked[i];
      assign blocked[i+1] = blocked[i] | req[i];
   end

   assign hit = blocked[N];

   always_comb begin
      win = '0;
      for (int i = 0; i < N; i++) begin
         if (grant[i]) win = IW'(i);
      end
   end

   // R8: the encoded winner is pending and nothing of lower index is
   always_comb begin
      if (hit) begin
         a_r8_lowest_wins: assert (req[win] &&
            ((req & ((N'(1) << win) - N'(1))) == '0));
      end
   end
endmodule

// File: rtl/psr_saved_bank.sv
module psr_saved_bank #(
   parameter int         W    = 32,
   parameter int         N    = 5,
   parameter logic [W-1:0] INIT = '0,
   parameter logic [W-1:0] LIVE = '1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [$clog2(N)-1:0] widx,
   input  logic [W/8-1:0]       wbyte,
   input  logic [W-1:0]         wdata,
   input  logic [$clog2(N)-1:0] ridx,
   output logic [W-1:0]         rdata
);
   localparam int NB = W / 8;
   localparam int IW = $clog2(N);

   logic [W-1:0] word_q [N];

   for (genvar s = 0; s < N; s++) begin : g_slot
      logic         sel;
      logic [W-1:0] q;

      assign sel = we && (widx == IW'(s));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= INIT;
         end else if (sel) begin
            for (int b = 0; b < NB; b++) begin
               if (wbyte[b]) q[8*b +: 8] <= wdata[8*b +: 8] & LIVE[8*b +: 8];
            end
         end
      end

      assign word_q[s] = q;
   end

   assign rdata = (ridx < IW'(N)) ? word_q[ridx] : '0;
endmodule

// File: rtl/psr_next.sv
module psr_next
   import psr_pkg::*;
#(
   parameter int W  = PSR_W,
   parameter int EW = 3,
   parameter int BW = 3
) (
   input  logic [W-1:0]   cur,
   input  logic [W-1:0]   sv_rd,
   input  logic           exc_hit,
   input  logic [EW-1:0]  exc_win,
   input  logic           ret_req,
   input  logic           flag_we,
   input  logic [3:0]     flag_nzcv,
   input  logic           sat_set,
   input  logic           msr_we,
   input  logic           msr_saved,
   input  logic [W/8-1:0] msr_bmask,
   input  logic [W-1:0]   msr_data,
   output logic [W-1:0]   nxt,
   output logic           sv_we,
   output logic [BW-1:0]  sv_idx,
   output logic [W/8-1:0] sv_bmask,
   output logic [W-1:0]   sv_data
);
   localparam int NB  = W / 8;
   localparam int TOP = NB - 1;

   logic [MODE_W-1:0] mode;
   logic [MODE_W-1:0] tgt;
   logic              banked;
   logic              is_user;

   assign mode    = cur[MODE_W-1:0];
   assign banked  = mode_banked(mode);
   assign is_user = (mode == M_USR);
   assign tgt     = exc_target(exc_win);

   always_comb begin
      nxt      = cur;
      sv_we    = 1'b0;
      sv_idx   = bank_of(mode);
      sv_bmask = msr_bmask;
      sv_data  = msr_data;
      if (exc_hit) begin
         sv_we              = 1'b1;
         sv_idx             = bank_of(tgt);
         sv_bmask           = '1;
         sv_data            = cur;
         nxt[MODE_W-1:0]    = tgt;
         nxt[BIT_I]         = 1'b1;
         nxt[BIT_T]         = 1'b0;
         nxt[BIT_J]         = 1'b0;
         if (exc_win == EX_RESET || exc_win == EX_FIQ) nxt[BIT_F] = 1'b1;
      end else if (ret_req && banked) begin
         nxt = sv_rd & LIVE_BITS;
         if (!mode_ok(sv_rd[MODE_W-1:0])) nxt[MODE_W-1:0] = mode;
      end else begin
         if (flag_we) nxt[BIT_N:BIT_V] = flag_nzcv;
         if (sat_set) nxt[BIT_Q] = 1'b1;
         if (msr_we && msr_saved) begin
            sv_we = banked;
         end else if (msr_we) begin
            for (int b = 0; b < NB; b++) begin
               if (msr_bmask[b] && (b == TOP || !is_user))
                  nxt[8*b +: 8] = msr_data[8*b +: 8];
            end
            if (msr_bmask[0] && !is_user && !mode_ok(msr_data[MODE_W-1:0]))
               nxt[MODE_W-1:0] = mode;
         end
         nxt = nxt & LIVE_BITS;
      end
   end
endmodule

// File: rtl/psr_bank.sv
module psr_bank
   import psr_pkg::*;
#(
   parameter int WORD_W   = PSR_W,
   parameter int NUM_EXC  = EXC_N,
   parameter int NUM_BANK = BANK_N
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                flag_we,
   input  logic [3:0]          flag_nzcv,
   input  logic                sat_set,
   input  logic                msr_we,
   input  logic                msr_saved,
   input  logic [WORD_W/8-1:0] msr_bmask,
   input  logic [WORD_W-1:0]   msr_data,
   input  logic [NUM_EXC-1:0]  exc_req,
   input  logic                ret_req,
   input  logic                rd_saved,
   output logic [WORD_W-1:0]   rd_data,
   output logic [MODE_W-1:0]   cur_mode,
   output logic                irq_off,
   output logic                fiq_off,
   output logic [1:0]          isa_state,
   output logic [3:0]          cond_nzcv
);
   localparam int BYTES = WORD_W / 8;
   localparam int EW    = $clog2(NUM_EXC);
   localparam int BW    = $clog2(NUM_BANK);

   if (WORD_W != 32) begin : g_bad_width
      $error("psr_bank: WORD_W must be 32");
   end
   if (NUM_EXC != 7 || NUM_BANK != 5) begin : g_bad_count
      $error("psr_bank: seven exception classes and five saved slots required");
   end

   logic [WORD_W-1:0] cur_q;
   logic [WORD_W-1:0] cur_nxt;
   logic [WORD_W-1:0] sv_rd;
   logic [WORD_W-1:0] sv_data;
   logic [BYTES-1:0]  sv_bmask;
   logic [BW-1:0]     sv_idx;
   logic              sv_we;
   logic              exc_hit;
   logic [EW-1:0]     exc_win;
   logic              banked;

   psr_exc_arb #(.N(NUM_EXC)) u_arb (
      .req (exc_req),
      .hit (exc_hit),
      .win (exc_win)
   );

   psr_saved_bank #(
      .W    (WORD_W),
      .N    (NUM_BANK),
      .INIT (SAVED_INIT),
      .LIVE (LIVE_BITS)
   ) u_saved (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (sv_we),
      .widx  (sv_idx),
      .wbyte (sv_bmask),
      .wdata (sv_data),
      .ridx  (bank_of(cur_q[MODE_W-1:0])),
      .rdata (sv_rd)
   );

   psr_next #(.W(WORD_W), .EW(EW), .BW(BW)) u_next (
      .cur       (cur_q),
      .sv_rd     (sv_rd),
      .exc_hit   (exc_hit),
      .exc_win   (exc_win),
      .ret_req   (ret_req),
      .flag_we   (flag_we),
      .flag_nzcv (flag_nzcv),
      .sat_set   (sat_set),
      .msr_we    (msr_we),
      .msr_saved (msr_saved),
      .msr_bmask (msr_bmask),
      .msr_data  (msr_data),
      .nxt       (cur_nxt),
      .sv_we     (sv_we),
      .sv_idx    (sv_idx),
      .sv_bmask  (sv_bmask),
      .sv_data   (sv_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_q <= BOOT_WORD;
      else        cur_q <= cur_nxt;
   end

   assign banked    = mode_banked(cur_q[MODE_W-1:0]);
   assign rd_data   = rd_saved ? (banked ? sv_rd : '0) : cur_q;
   assign cur_mode  = cur_q[MODE_W-1:0];
   assign irq_off   = cur_q[BIT_I];
   assign fiq_off   = cur_q[BIT_F];
   assign isa_state = cur_q[BIT_J] ? 2'b10 : {1'b0, cur_q[BIT_T]};
   assign cond_nzcv = cur_q[BIT_N:BIT_V];

   // R3: saturation bit survives every cycle without a byte-3 write or restore
   a_r3_sat_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_q[BIT_Q] && !(msr_we && !msr_saved && msr_bmask[BYTES-1]) && !ret_req)
      |=> cur_q[BIT_Q]);

   // R2: an uncontested flag update reaches the condition outputs
   a_r2_flags_land: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we && exc_req == '0 && !ret_req && !(msr_we && !msr_saved && msr_bmask[BYTES-1]))
      |=> cond_nzcv == $past(flag_nzcv));

   // R7: any entry masks interrupts and forces 32-bit state
   a_r7_entry_state: assert property (@(posedge clk) disable iff (!rst_n)
      (|exc_req) |=> (irq_off && isa_state == 2'b00));

   // R7: a lone fast interrupt lands in its mode with fast interrupts masked
   a_r7_fiq_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req[2] && exc_req[1:0] == 2'b00) |=> (cur_mode == M_FIQ && fiq_off));

   // R5: user mode keeps its control byte and only leaves through an exception
   a_r5_user_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == M_USR && exc_req == '0) |=> (cur_mode == M_USR && $stable(cur_q[7:0])));

   // R4: unimplemented bits read as zero on either read selection
   a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & ~LIVE_BITS) == '0);

   // R6: the mode field never holds an unlisted encoding
   a_r6_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
      mode_ok(cur_mode));
endmodule

// File: tb/sim_psr_bank.sv
module sim_psr_bank;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flag_we = 1'b0;
   logic [3:0]  flag_nzcv = '0;
   logic        sat_set = 1'b0;
   logic        msr_we = 1'b0;
   logic        msr_saved = 1'b0;
   logic [3:0]  msr_bmask = '0;
   logic [31:0] msr_data = '0;
   logic [6:0]  exc_req = '0;
   logic        ret_req = 1'b0;
   logic        rd_saved = 1'b0;
   logic [31:0] rd_data;
   logic [4:0]  cur_mode;
   logic        irq_off, fiq_off;
   logic [1:0]  isa_state;
   logic [3:0]  cond_nzcv;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] m_cur;
   logic [31:0] m_sv [5];

   always #(CLK_PERIOD/2) clk = ~clk;

   psr_bank u0 (
      .clk(clk), .rst_n(rst_n), .flag_we(flag_we), .flag_nzcv(flag_nzcv),
      .sat_set(sat_set), .msr_we(msr_we), .msr_saved(msr_saved),
      .msr_bmask(msr_bmask), .msr_data(msr_data), .exc_req(exc_req),
      .ret_req(ret_req), .rd_saved(rd_saved), .rd_data(rd_data),
      .cur_mode(cur_mode), .irq_off(irq_off), .fiq_off(fiq_off),
      .isa_state(isa_state), .cond_nzcv(cond_nzcv)
   );

   function automatic bit legal(input logic [4:0] m);
      return m == 5'h10 || m == 5'h11 || m == 5'h12 || m == 5'h13 ||
             m == 5'h17 || m == 5'h1B || m == 5'h1F;
   endfunction

   function automatic int slot(input logic [4:0] m);
      case (m)
         5'h11: return 0;
         5'h12: return 1;
         5'h13: return 2;
         5'h17: return 3;
         5'h1B: return 4;
         default: return -1;
      endcase
   endfunction

   function automatic logic [4:0] tmode(input int k);
      case (k)
         0: return 5'h13;
         1: return 5'h17;
         2: return 5'h11;
         3: return 5'h12;
         4: return 5'h17;
         5: return 5'h1B;
         default: return 5'h13;
      endcase
   endfunction

   task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
      end
   endtask

   task automatic compare(input string tag);
      int b;
      logic [31:0] sv_exp;
      b = slot(m_cur[4:0]);
      sv_exp = (b >= 0) ? m_sv[b] : 32'h0;
      chk(tag, "word", rd_data, m_cur);
      chk(tag, "mode", {27'h0, cur_mode}, {27'h0, m_cur[4:0]});
      chk(tag, "irq_off", {31'h0, irq_off}, {31'h0, m_cur[7]});
      chk(tag, "fiq_off", {31'h0, fiq_off}, {31'h0, m_cur[6]});
      chk(tag, "isa_state", {30'h0, isa_state},
          {30'h0, (m_cur[24] ? 2'b10 : {1'b0, m_cur[5]})});
      chk(tag, "cond_nzcv", {28'h0, cond_nzcv}, {28'h0, m_cur[31:28]});
      rd_saved = 1'b1;
      #1;
      chk(tag, "saved", rd_data, sv_exp);
      rd_saved = 1'b0;
      #1;
   endtask

   task automatic cyc(input string tag, input logic [6:0] er, input logic rt,
                      input logic fw, input logic [3:0] fn, input logic ss,
                      input logic mw, input logic ms, input logic [3:0] mm,
                      input logic [31:0] md);
      logic [31:0] e;
      int b;
      int k;
      logic [4:0] tm;
      exc_req = er; ret_req = rt; flag_we = fw; flag_nzcv = fn; sat_set = ss;
      msr_we = mw; msr_saved = ms; msr_bmask = mm; msr_data = md;
      e = m_cur;
      b = slot(m_cur[4:0]);
      if (er != 7'h0) begin
         k = 0;
         while (!er[k]) k++;
         tm = tmode(k);
         m_sv[slot(tm)] = m_cur;
         e[4:0] = tm;
         e[7] = 1'b1;
         if (k == 0 || k == 2) e[6] = 1'b1;
         e[5] = 1'b0;
         e[24] = 1'b0;
      end else if (rt && b >= 0) begin
         e = m_sv[b] & 32'hF900_00FF;
         if (!legal(m_sv[b][4:0])) e[4:0] = m_cur[4:0];
      end else begin
         if (fw) e[31:28] = fn;
         if (ss) e[27] = 1'b1;
         if (mw && ms) begin
            if (b >= 0) begin
               for (int j = 0; j < 4; j++)
                  if (mm[j]) m_sv[b][8*j +: 8] = md[8*j +: 8] & 8'(32'hF900_00FF >> (8*j));
            end
         end else if (mw) begin
            for (int j = 0; j < 4; j++)
               if (mm[j] && (j == 3 || m_cur[4:0] != 5'h10)) e[8*j +: 8] = md[8*j +: 8];
            if (mm[0] && m_cur[4:0] != 5'h10 && !legal(md[4:0])) e[4:0] = m_cur[4:0];
         end
         e = e & 32'hF900_00FF;
      end
      @(posedge clk);
      #1;
      exc_req = '0; ret_req = 1'b0; flag_we = 1'b0; sat_set = 1'b0;
      msr_we = 1'b0; msr_saved = 1'b0;
      m_cur = e;
      compare(tag);
   endtask

   task automatic wr(input string tag, input logic [3:0] mm, input logic [31:0] md);
      cyc(tag, 7'h0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, mm, md);
   endtask

   task automatic wr_sv(input string tag, input logic [3:0] mm, input logic [31:0] md);
      cyc(tag, 7'h0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b1, mm, md);
   endtask

   task automatic ret(input string tag);
      cyc(tag, 7'h0, 1'b1, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 4'h0, 32'h0);
   endtask

   task automatic exc(input string tag, input logic [6:0] er);
      cyc(tag, er, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 4'h0, 32'h0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog: got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] lf;
      m_cur = 32'h0000_00D3;
      for (int s = 0; s < 5; s++) m_sv[s] = 32'h0000_0010;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      compare("R1");

      // R2: every flag pattern
      for (int n = 0; n < 16; n++)
         cyc("R2", 7'h0, 1'b0, 1'b1, 4'(n), 1'b0, 1'b0, 1'b0, 4'h0, 32'h0);

      // R3: sticky saturation
      cyc("R3", 7'h0, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0, 4'h0, 32'h0);
      cyc("R3", 7'h0, 1'b0, 1'b1, 4'h5, 1'b0, 1'b0, 1'b0, 4'h0, 32'h0);
      wr("R3", 4'h7, 32'h0000_00D3);
      wr("R3", 4'h8, 32'h0000_0000);
      // R11: byte-3 write beats flag update and saturation pulse
      cyc("R11", 7'h0, 1'b0, 1'b1, 4'hF, 1'b1, 1'b1, 1'b0, 4'h8, 32'h5000_0000);

      // R4: every byte mask, two data patterns
      for (int mk = 0; mk < 16; mk++)
         wr("R4", 4'(mk), (mk % 2 == 0) ? 32'hFFFF_FFD3 : 32'h5A5A_5A1F);
      wr("R4", 4'h1, 32'h0000_00D3);

      // R6 and R12: illegal mode, instruction states
      wr("R6", 4'h1, 32'h0000_00E5);
      wr("R12", 4'h8, 32'h0100_0000);
      wr("R12", 4'h8, 32'h0000_0000);
      wr("R12", 4'h1, 32'h0000_00D3);

      // R10 then R9: saved access and restore in supervisor mode
      wr_sv("R10", 4'h5, 32'h1234_5678);
      wr_sv("R10", 4'hF, 32'hF1AB_CD92);
      ret("R9");
      wr_sv("R9", 4'h1, 32'h0000_0005);
      ret("R9");

      // R7 and R8: all request patterns from a distinct state
      for (int r = 1; r < 128; r++) begin
         logic [6:0] rv;
         rv = 7'(r);
         wr("R7", 4'hF, {rv[3:0], 3'b000, rv[4], 16'h0000, 8'h3F});
         exc("R8", rv);
      end

      // R5, R9, R10 in user mode
      wr("R5", 4'hF, 32'hA000_0010);
      wr("R5", 4'h1, 32'h0000_00D3);
      wr("R5", 4'h8, 32'h7100_0000);
      wr("R5", 4'h6, 32'hFFFF_FFFF);
      ret("R9");
      wr_sv("R10", 4'hF, 32'hFFFF_FFFF);
      exc("R7", 7'h40);

      // R11: precedence within one cycle
      cyc("R11", 7'h08, 1'b1, 1'b1, 4'hF, 1'b1, 1'b1, 1'b0, 4'hF, 32'h0);
      cyc("R11", 7'h00, 1'b1, 1'b1, 4'h3, 1'b1, 1'b1, 1'b0, 4'hF, 32'h0000_001F);

      // R11: mixed stimulus against the reference model
      lf = 32'hACE1_2468;
      for (int t = 0; t < 3000; t++) begin
         logic [31:0] md;
         lf = {lf[30:0], 1'b0} ^ (lf[31] ? 32'h0400_0007 : 32'h0);
         md = lf ^ {lf[15:0], lf[31:16]};
         cyc("R11", (lf[7:3] == 5'h0) ? lf[14:8] : 7'h0, lf[15] & lf[16] & lf[17],
             lf[18], lf[22:19], lf[23] & lf[24], lf[25], lf[26], lf[30:27], md);
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule